// File: doc/BRIEF.md
# Acquisition Storage Qualifier with Block Storage

This block sits between the sampling front end of a capture engine and its acquisition memory. For each accepted sample it decides whether the sample is written. Three sources take part in the decision. The lowest is a global storage condition, evaluated elsewhere and presented as one bit. Above it is a storage command tied to the current trigger state. Above both are per-sample event commands that force storage on or off.

Each acquisition starts with a pulse on `acq_start`, which latches the acquisition's configuration. That configuration covers four things: whether storage starts enabled or disabled, whether block storage is requested, whether violation-information storage is on, and whether the storage condition was built from counter/timer terms. Counter/timer terms are not allowed in the storage condition, so such a configuration is rejected.

In block mode the block also writes a fixed number of samples before and after every qualified sample. It uses a delay line, so the output stream lags the input by the pre-window depth. A flush input drains the delay line when acquisition ends.

Top module: `store_qualifier`

## Requirements
- R1: With no event or state command present, a valid sample is stored when `glob_cond` is 1, storage is enabled and the configuration was not rejected.
- R2: When `st_cmd_vld` is 1, the stored/not-stored result equals `st_cmd_store`, whatever `glob_cond` is.
- R3: `evt_on`=1 stores the current sample and `evt_off`=1 drops it, overriding both state and global sources; when both are 1, `evt_on` wins. Neither has any effect on later samples.
- R4: At `acq_start`, storage enable is loaded from `start_en` (reset value 1). When enable is 0, the global condition is ignored until the first valid sample carrying a state command, after which enable is 1.
- R5: `acq_start` with `ctr_sel`=1 makes `cfg_err` 1 from the next cycle until the next `acq_start`, and the global condition then never stores; state and event commands still work.
- R6: Without block mode, a sample presented in cycle t appears on `m_data` with `m_we` in cycle t+1. `m_we` is 0 in any cycle that follows a cycle with neither `s_valid` nor `flush`.
- R7: In block mode (`blk_en`=1 at `acq_start`), sample k is written when any sample in k-31..k+31 of the same acquisition is qualified. Sample k is output one cycle after input sample k+31 is accepted, or after the flush cycle that stands in for it.
- R8: Overlapping block windows merge; every sample is written at most once, in input order.
- R9: `viol_en`=1 at `acq_start` disables block mode for that acquisition, even when `blk_en`=1.
- R10: In block mode, each `flush` cycle with `s_valid`=0 advances the delay line by one slot, so 31 flush cycles write out every pending sample of the post-window.
- R11: After reset, `m_we` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | Start of acquisition; latches configuration and clears the delay line |
| start_en | input | 1 | Storage enable state at start of acquisition |
| blk_en | input | 1 | Block storage requested |
| viol_en | input | 1 | Violation-information storage on (forces block mode off) |
| ctr_sel | input | 1 | Storage condition uses counter/timer terms (rejected) |
| s_valid | input | 1 | Input sample valid |
| s_data | input | DW | Input sample |
| glob_cond | input | 1 | Global storage condition result |
| st_cmd_vld | input | 1 | Current trigger state defines a storage command |
| st_cmd_store | input | 1 | State storage command: 1 store, 0 do not store |
| evt_on | input | 1 | Event command: store this sample |
| evt_off | input | 1 | Event command: drop this sample |
| flush | input | 1 | Drain one slot of the delay line |
| m_we | output | 1 | Memory write enable |
| m_data | output | DW | Sample toward memory |
| cfg_err | output | 1 | Configuration rejected |

## Verification
Two things can hit the same sample. The first is the priority chain: an event command, a state command and the global condition can all be present on one sample. The bench drives all three with conflicting values and checks the stored bit against a reference model's priority. The second is block windows: a sample can sit inside the post-window of an earlier qualified sample and the pre-window of a later one. Two qualified samples 40 apart provoke this, and the bench compares the write strobe on every cycle and the total write count, which must show each merged sample exactly once.

// File: rtl/stq_pkg.sv
package stq_pkg;
    // configuration latched at acquisition start
    typedef struct packed {
        logic blk;   // block storage active
        logic bad;   // configuration rejected
    } acq_cfg_t;
endpackage

// File: rtl/stq_decide.sv
module stq_decide (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_en,
    input  logic bad,
    input  logic s_valid,
    input  logic glob_cond,
    input  logic st_vld,
    input  logic st_store,
    input  logic evt_on,
    input  logic evt_off,
    output logic qual
);
    typedef struct packed {
        logic en;
    } dec_t;

    dec_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.en = start_en;
        end else if (s_valid && st_vld) begin
            r_d.en = 1'b1;
        end
        // priority: event, then trigger state, then global condition
        if (evt_on) begin
            qual = 1'b1;
        end else if (evt_off) begin
            qual = 1'b0;
        end else if (st_vld) begin
            qual = st_store;
        end else begin
            qual = r_q.en & ~bad & glob_cond;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/stq_window.sv
module stq_window #(
    parameter int DW   = 16,
    parameter int PRE  = 31,
    parameter int POST = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift,
    input  logic          in_vld,
    input  logic          in_q,
    input  logic [DW-1:0] in_data,
    output logic          out_we,
    output logic [DW-1:0] out_data
);
    localparam int CW   = $clog2(POST + 1);
    localparam int TAIL = PRE - 1;

    typedef struct packed {
        logic [PRE-1:0][DW-1:0] dat;
        logic [PRE-1:0]         qf;
        logic [PRE-1:0]         vf;
        logic [CW-1:0]          pc;
        logic                   we;
        logic [DW-1:0]          od;
    } win_t;

    win_t r_d, r_q;
    logic any_q;

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        // tail sample plus the PRE samples after it
        any_q  = in_q | (|r_q.qf);
        if (clr) begin
            r_d = '0;
        end else if (shift) begin
            r_d.we = r_q.vf[TAIL] & (any_q | (r_q.pc != '0));
            r_d.od = r_q.dat[TAIL];
            if (r_q.vf[TAIL] && r_q.qf[TAIL]) begin
                r_d.pc = CW'(POST);
            end else if (r_q.pc != '0) begin
                r_d.pc = r_q.pc - 1'b1;
            end
            for (int i = PRE - 1; i > 0; i--) begin
                r_d.dat[i] = r_q.dat[i-1];
                r_d.qf[i]  = r_q.qf[i-1];
                r_d.vf[i]  = r_q.vf[i-1];
            end
            r_d.dat[0] = in_data;
            r_d.qf[0]  = in_q & in_vld;
            r_d.vf[0]  = in_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_we   = r_q.we;
    assign out_data = r_q.od;
endmodule

// File: rtl/store_qualifier.sv
module store_qualifier #(
    parameter int DW   = 16,
    parameter int PRE  = 31,
    parameter int POST = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_start,
    input  logic          start_en,
    input  logic          blk_en,
    input  logic          viol_en,
    input  logic          ctr_sel,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          glob_cond,
    input  logic          st_cmd_vld,
    input  logic          st_cmd_store,
    input  logic          evt_on,
    input  logic          evt_off,
    input  logic          flush,
    output logic          m_we,
    output logic [DW-1:0] m_data,
    output logic          cfg_err
);
    import stq_pkg::*;

    typedef struct packed {
        acq_cfg_t      cfg;
        logic          we;
        logic [DW-1:0] dat;
    } top_t;

    top_t r_d, r_q;
    logic qual;
    logic win_shift;
    logic win_we;
    logic [DW-1:0] win_data;

    stq_decide u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (acq_start),
        .start_en (start_en),
        .bad      (r_q.cfg.bad),
        .s_valid  (s_valid),
        .glob_cond(glob_cond),
        .st_vld   (st_cmd_vld),
        .st_store (st_cmd_store),
        .evt_on   (evt_on),
        .evt_off  (evt_off),
        .qual     (qual)
    );

    assign win_shift = r_q.cfg.blk & ~acq_start & (s_valid | flush);

    stq_window #(.DW(DW), .PRE(PRE), .POST(POST)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acq_start),
        .shift   (win_shift),
        .in_vld  (s_valid),
        .in_q    (qual & s_valid),
        .in_data (s_data),
        .out_we  (win_we),
        .out_data(win_data)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (acq_start) begin
            r_d.cfg.blk = blk_en & ~viol_en;
            r_d.cfg.bad = ctr_sel;
        end else if (s_valid && !r_q.cfg.blk) begin
            r_d.we  = qual;
            r_d.dat = s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign m_we    = r_q.cfg.blk ? win_we   : r_q.we;
    assign m_data  = r_q.cfg.blk ? win_data : r_q.dat;
    assign cfg_err = r_q.cfg.bad;
endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acq_start,
    input logic          viol_en,
    input logic          ctr_sel,
    input logic          s_valid,
    input logic [DW-1:0] s_data,
    input logic          evt_on,
    input logic          evt_off,
    input logic          flush,
    input logic          blk_i,
    input logic          m_we,
    input logic [DW-1:0] m_data,
    input logic          cfg_err
);
    AST_EVT_ON_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_start && !blk_i && s_valid && evt_on) |=> m_we); // R3

    AST_EVT_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_start && !blk_i && s_valid && evt_off && !evt_on) |=> !m_we); // R3

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_start && !blk_i && s_valid) |=> (m_data == $past(s_data))); // R6

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_start && !s_valid && !flush) |=> !m_we); // R6

    AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start && ctr_sel) |=> cfg_err); // R5

    AST_VIOL_BLOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start && viol_en) |=> !blk_i); // R9
endmodule

bind store_qualifier stq_checker #(.DW(DW)) u_stq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_start(acq_start),
    .viol_en  (viol_en),
    .ctr_sel  (ctr_sel),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .evt_on   (evt_on),
    .evt_off  (evt_off),
    .flush    (flush),
    .blk_i    (r_q.cfg.blk),
    .m_we     (m_we),
    .m_data   (m_data),
    .cfg_err  (cfg_err)
);

// File: tb/test_store_qualifier.sv
`timescale 1ns/1ps
module test_store_qualifier;
    localparam int DW = 16;
    localparam int PRE = 31;
    localparam int POST = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_start = 0, start_en = 1, blk_en = 0, viol_en = 0, ctr_sel = 0;
    logic s_valid = 0, glob_cond = 0, st_cmd_vld = 0, st_cmd_store = 0;
    logic evt_on = 0, evt_off = 0, flush = 0;
    logic [DW-1:0] s_data = '0;
    logic m_we, cfg_err;
    logic [DW-1:0] m_data;

    always #2 clk = ~clk;

    store_qualifier #(.DW(DW), .PRE(PRE), .POST(POST)) i_store_qualifier (
        .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .start_en(start_en),
        .blk_en(blk_en), .viol_en(viol_en), .ctr_sel(ctr_sel),
        .s_valid(s_valid), .s_data(s_data), .glob_cond(glob_cond),
        .st_cmd_vld(st_cmd_vld), .st_cmd_store(st_cmd_store),
        .evt_on(evt_on), .evt_off(evt_off), .flush(flush),
        .m_we(m_we), .m_data(m_data), .cfg_err(cfg_err)
    );

    integer checks = 0, errors = 0, wcnt = 0;
    string  cur_req = "R11";

    // reference model state
    logic          m_en = 1, m_blk = 0, m_bad = 0;
    logic          exp_we = 0, exp_bad = 0;
    logic [DW-1:0] exp_data = '0;
    logic [DW-1:0] qd[$];
    logic          qq[$];
    integer        nshift = 0;

    task automatic chk(input bit ok, input string req, input integer act, input integer exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic q;
        if (!rst_n) begin
            m_en = 1; m_blk = 0; m_bad = 0; exp_we = 0; exp_bad = 0;
            qd.delete(); qq.delete(); nshift = 0;
        end else if (acq_start) begin
            m_en = start_en; m_blk = blk_en & ~viol_en; m_bad = ctr_sel;
            exp_bad = ctr_sel; exp_we = 0;
            qd.delete(); qq.delete(); nshift = 0;
        end else begin
            if (evt_on) q = 1;
            else if (evt_off) q = 0;
            else if (st_cmd_vld) q = st_cmd_store;
            else q = m_en & ~m_bad & glob_cond;
            if (s_valid && st_cmd_vld) m_en = 1;
            exp_we = 0;
            if (!m_blk) begin
                if (s_valid) begin
                    exp_we = q; exp_data = s_data;
                end
            end else begin
                if (s_valid) begin
                    qd.push_back(s_data); qq.push_back(q);
                end
                if (s_valid || flush) begin
                    integer k;
                    k = nshift - PRE;
                    nshift++;
                    if (k >= 0 && k < qd.size()) begin
                        bit any;
                        any = 0;
                        for (int j = k - POST; j <= k + PRE; j++)
                            if (j >= 0 && j < qq.size()) if (qq[j]) any = 1;
                        exp_we = any; exp_data = qd[k];
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(m_we === exp_we, cur_req, m_we, exp_we);
            if (exp_we) chk(m_data === exp_data, cur_req, m_data, exp_data);
            chk(cfg_err === exp_bad, "R5", cfg_err, exp_bad);
            if (m_we) wcnt++;
        end
    end

    task automatic step(input logic v, input logic [DW-1:0] d, input logic g,
                        input logic sv, input logic ss, input logic on, input logic off);
        s_valid = v; s_data = d; glob_cond = g; st_cmd_vld = sv;
        st_cmd_store = ss; evt_on = on; evt_off = off; flush = 0;
        @(negedge clk);
    endtask

    task automatic start(input logic se, input logic be, input logic ve, input logic cs);
        step(0, 0, 0, 0, 0, 0, 0);
        acq_start = 1; start_en = se; blk_en = be; viol_en = ve; ctr_sel = cs;
        @(negedge clk);
        acq_start = 0;
    endtask

    task automatic do_flush(input integer n);
        for (int i = 0; i < n; i++) begin
            s_valid = 0; evt_on = 0; evt_off = 0; st_cmd_vld = 0; flush = 1;
            @(negedge clk);
        end
        flush = 0;
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    // block run of n samples, qualified by event on at listed positions
    task automatic blk_run(input integer n, input integer p0, input integer p1);
        for (int i = 0; i < n; i++)
            step(1, DW'(16'h2000 + i), 0, 0, 0, (i == p0) || (i == p1), 0);
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4ns * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(m_we === 1'b0, "R11", m_we, 0);
        chk(cfg_err === 1'b0, "R11", cfg_err, 0);
        rst_n = 1;
        @(negedge clk);

        // R1, R2, R3 priority in bypass mode
        start(1, 0, 0, 0);
        cur_req = "R1";
        step(1, 16'h0001, 1, 0, 0, 0, 0);
        step(1, 16'h0002, 0, 0, 0, 0, 0);
        step(0, 16'h0003, 1, 0, 0, 0, 0);
        step(1, 16'h0004, 1, 0, 0, 0, 0);
        cur_req = "R2";
        step(1, 16'h0011, 1, 1, 0, 0, 0);
        step(1, 16'h0012, 0, 1, 1, 0, 0);
        cur_req = "R3";
        step(1, 16'h0021, 0, 1, 0, 1, 0);
        step(1, 16'h0022, 1, 1, 1, 0, 1);
        step(1, 16'h0023, 0, 0, 0, 1, 1);
        step(1, 16'h0024, 0, 0, 0, 0, 0);
        step(1, 16'h0025, 1, 0, 0, 0, 0);
        cur_req = "R6";
        step(0, 0, 0, 0, 0, 0, 0);

        // R4 start disabled
        start(0, 0, 0, 0);
        cur_req = "R4";
        step(1, 16'h0031, 1, 0, 0, 0, 0);
        step(1, 16'h0032, 1, 0, 0, 0, 0);
        step(1, 16'h0033, 0, 1, 0, 0, 0);
        step(1, 16'h0034, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        // R5 rejected configuration
        start(1, 0, 0, 1);
        cur_req = "R5";
        chk(cfg_err === 1'b1, "R5", cfg_err, 1);
        step(1, 16'h0041, 1, 0, 0, 0, 0);
        step(1, 16'h0042, 1, 0, 0, 1, 0);
        step(1, 16'h0043, 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        start(1, 0, 0, 0);
        chk(cfg_err === 1'b0, "R5", cfg_err, 0);

        // R7 single window
        start(1, 1, 0, 0);
        cur_req = "R7";
        wcnt = 0;
        blk_run(100, 40, -1);
        do_flush(PRE);
        chk(wcnt == 63, "R7", wcnt, 63);

        // R8 overlapping windows merge
        start(1, 1, 0, 0);
        cur_req = "R8";
        wcnt = 0;
        blk_run(100, 10, 50);
        do_flush(PRE);
        chk(wcnt == 82, "R8", wcnt, 82);

        // R10 flush drains post-window
        start(1, 1, 0, 0);
        cur_req = "R10";
        wcnt = 0;
        blk_run(100, 95, -1);
        chk(wcnt == 5, "R10", wcnt, 5);
        do_flush(PRE);
        chk(wcnt == 36, "R10", wcnt, 36);

        // R9 violation storage forces block off: next-cycle write
        start(1, 1, 1, 0);
        cur_req = "R9";
        step(1, 16'h0051, 0, 0, 0, 1, 0);
        chk(m_we === 1'b1, "R9", m_we, 1);
        chk(m_data === 16'h0051, "R9", m_data, 16'h0051);
        step(0, 0, 0, 0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule